// File: doc/BRIEF.md
# Display Frame CRC32 Signature Unit

This unit watches the parallel pixel output of a display controller and condenses every pixel word that actually leaves the interface during one frame into a 32-bit CRC signature. The signature is built from what was driven onto the pins, not from what sits in frame memory. Comparing it against a signature computed from the intended image shows whether the displayed frame was corrupted on its way out.

Each qualified 32-bit word is mirrored end to end and then folded, one word per pixel clock, into a reflected CRC32 register that starts at all ones for every frame. When the next frame-start pulse arrives, the mirrored register contents are latched into a status register. A one-cycle strobe marks the update. With no final XOR, the result equals a CRC with the normal polynomial, fed bit 31 first, with an all-ones start value and no final inversion.

The unit runs in the pixel clock domain. Its asynchronous active-low reset is assumed to be released synchronously by the clock's reset tree. A level enable can switch the unit off; while it is off, the last reported signature stays readable.

Top module: `fsig_frame_sig`

## Requirements
- R1: While reset is asserted and after its release, before any report, the signature output reads 0x00000000 and the strobe is low.
- R2: The CRC register starts from 0xFFFFFFFF at every frame start, so a frame with no qualified words reports 0xFFFFFFFF.
- R3: The reported value equals the CRC with polynomial 0x04C11DB7, register start value 0xFFFFFFFF and no final XOR. Words are taken in order, each one most significant bit (bit 31) first. This equals a reflected 0xEDB88320 engine fed with mirrored words, whose result is mirrored again.
- R4: A word counts only in a cycle where the pixel-valid input is high. Back-to-back valid cycles each count one word, and idle cycles leave the CRC unchanged.
- R5: A frame-start pulse that closes a started frame updates the signature output after that clock edge. The strobe is high for exactly that one following cycle.
- R6: The first frame-start after reset produces no report, and words presented before it are ignored.
- R7: A valid word that coincides with a frame-start belongs to the new frame: the closing frame's signature excludes it, and the next frame's signature starts with it.
- R8: While enable is low, the signature output holds, no strobe is raised and inputs are ignored. Any open frame is abandoned, so the first frame-start after re-enabling produces no report.
- R9: The smallest frame, 8 pixels by 2 lines (16 words sent back to back), is signed correctly.
- R10: Between reports the signature output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Unit enable, level |
| frame_start_i | input | 1 | One-cycle frame-start (vertical sync) pulse |
| pix_valid_i | input | 1 | Data-enable qualifier for the pixel word |
| pix_data_i | input | WORD_W (32) | Pixel word leaving the output interface |
| sig_value_o | output | 32 | Signature of the last completed frame |
| sig_strobe_o | output | 1 | One-cycle pulse when sig_value_o is updated |

## Verification
The delicate coincidence is a frame-start pulse in the same cycle as a qualified pixel word. That single edge must both close the old frame and seed the new one with that word. The bench drives a word together with the closing pulse. It expects the reported signature to match a bit-serial reference over the earlier words only. The next report must match a reference whose first word is the overlapped one. The enable falling mid-frame is treated the same way, against a frame-start and words presented while the unit is off.

// File: rtl/fsig_pkg.sv
package fsig_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] REFL_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED  = '1;

  typedef logic [CRC_W-1:0] crc_t;

endpackage

// File: rtl/fsig_bitrev.sv
module fsig_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign out_o[i] = in_i[W-1-i];
  end

endmodule

// File: rtl/fsig_crc_step.sv
// One full word folded into a reflected CRC in a single cycle:
// an unrolled chain of LSB-first shift stages.
module fsig_crc_step
  import fsig_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  crc_t              crc_i,
  input  logic [WORD_W-1:0] word_i,
  output crc_t              crc_o
);

  crc_t chain [0:WORD_W];

  assign chain[0] = crc_i;

  for (genvar i = 0; i < WORD_W; i++) begin : g_stage
    logic fb;
    assign fb           = chain[i][0] ^ word_i[i];
    assign chain[i+1]   = (chain[i] >> 1) ^ ({CRC_W{fb}} & REFL_POLY);
  end

  assign crc_o = chain[WORD_W];

endmodule

// File: rtl/fsig_frame_ctl.sv
// Frame bracketing: tracks whether a frame is open and decides, per cycle,
// whether to seed the engine, fold a word, or report the closing frame.
module fsig_frame_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic frame_start_i,
  input  logic pix_valid_i,
  output logic load_seed_o,
  output logic advance_o,
  output logic report_o
);

  logic open_q;
  logic open_d;

  always_comb begin
    load_seed_o = enable_i & frame_start_i;
    report_o    = enable_i & frame_start_i & open_q;
    advance_o   = enable_i & pix_valid_i & (open_q | frame_start_i);
    if (enable_i) begin
      open_d = open_q | frame_start_i;
    end else begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/fsig_engine.sv
module fsig_engine
  import fsig_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_seed_i,
  input  logic              advance_i,
  input  logic [WORD_W-1:0] word_i,
  output crc_t              crc_o
);

  logic [WORD_W-1:0] word_flip;
  crc_t              crc_q;
  crc_t              crc_d;
  crc_t              step_base;
  crc_t              step_out;
  logic              crc_en;

  fsig_bitrev #(.W(WORD_W)) u_in_flip (
    .in_i  (word_i),
    .out_o (word_flip)
  );

  fsig_crc_step #(.WORD_W(WORD_W)) u_step (
    .crc_i  (step_base),
    .word_i (word_flip),
    .crc_o  (step_out)
  );

  always_comb begin
    step_base = load_seed_i ? CRC_SEED : crc_q;
    crc_en    = load_seed_i | advance_i;
    crc_d     = advance_i ? step_out : step_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= CRC_SEED;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

  AST_SEED_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_seed_i && !advance_i) |=> (crc_q == CRC_SEED)); // R2

  AST_IDLE_HOLDS_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_seed_i && !advance_i) |=> $stable(crc_q)); // R4

endmodule

// File: rtl/fsig_frame_sig.sv
module fsig_frame_sig
  import fsig_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              frame_start_i,
  input  logic              pix_valid_i,
  input  logic [WORD_W-1:0] pix_data_i,
  output logic [CRC_W-1:0]  sig_value_o,
  output logic              sig_strobe_o
);

  logic load_seed;
  logic advance;
  logic report;
  crc_t crc_acc;
  crc_t crc_flip;

  crc_t sig_q;
  crc_t sig_d;
  logic strobe_q;

  fsig_frame_ctl u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .frame_start_i (frame_start_i),
    .pix_valid_i   (pix_valid_i),
    .load_seed_o   (load_seed),
    .advance_o     (advance),
    .report_o      (report)
  );

  fsig_engine #(.WORD_W(WORD_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_seed_i (load_seed),
    .advance_i   (advance),
    .word_i      (pix_data_i),
    .crc_o       (crc_acc)
  );

  fsig_bitrev #(.W(CRC_W)) u_out_flip (
    .in_i  (crc_acc),
    .out_o (crc_flip)
  );

  always_comb begin
    sig_d = report ? crc_flip : sig_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      sig_q    <= sig_d;
      strobe_q <= report;
    end
  end

  assign sig_value_o  = sig_q;
  assign sig_strobe_o = strobe_q;

  AST_STROBE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_strobe_o |-> $past(frame_start_i && enable_i)); // R5

  AST_OFF_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !sig_strobe_o); // R8

  AST_VALUE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_strobe_o |-> $stable(sig_value_o)); // R10

endmodule

// File: tb/fsig_frame_sig_tb_top.sv
`timescale 1ns/1ps
module fsig_frame_sig_tb_top;

  typedef struct packed {
    logic [31:0] seed;
    logic [7:0]  len;
    logic [7:0]  gap;
  } vec_t;

  // seed, words in frame, idle cycle after every <gap> words (0 = none)
  localparam int NVEC = 6;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{32'h0000_0001, 8'd16, 8'd0},   // R9 minimum 8x2 frame
    '{32'h1234_5678, 8'd5,  8'd1},
    '{32'hDEAD_BEEF, 8'd40, 8'd2},
    '{32'h0BAD_F00D, 8'd1,  8'd0},
    '{32'h5555_AAAA, 8'd0,  8'd0},   // R2 empty frame
    '{32'hCAFE_0042, 8'd33, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        enable_i;
  logic        frame_start_i;
  logic        pix_valid_i;
  logic [31:0] pix_data_i;
  logic [31:0] sig_value_o;
  logic        sig_strobe_o;

  always #2 clk = ~clk;

  fsig_frame_sig dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .frame_start_i (frame_start_i),
    .pix_valid_i   (pix_valid_i),
    .pix_data_i    (pix_data_i),
    .sig_value_o   (sig_value_o),
    .sig_strobe_o  (sig_strobe_o)
  );

  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;
  logic [31:0] wbuf [0:63];
  int          wcnt;
  logic [31:0] lcg;
  logic [31:0] last_sig;

  // Bit-serial MSB-first reference, normal polynomial, no final XOR.
  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      for (int b = 31; b >= 0; b--) begin
        logic fb;
        fb = c[31] ^ wbuf[k][b];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_word();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic push_word(logic [31:0] w);
    @(negedge clk);
    frame_start_i = 1'b0;
    pix_valid_i   = 1'b1;
    pix_data_i    = w;
    wbuf[wcnt]    = w;
    wcnt++;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    frame_start_i = 1'b0;
    pix_valid_i   = 1'b0;
  endtask

  task automatic close_check(string tag);
    logic [31:0] exp;
    exp = ref_crc(wcnt);
    @(negedge clk);
    frame_start_i = 1'b1;
    pix_valid_i   = 1'b0;
    @(negedge clk);
    check({tag, " strobe"}, {31'd0, sig_strobe_o}, 32'd1);
    check({tag, " value"}, sig_value_o, exp);
    frame_start_i = 1'b0;
    @(negedge clk);
    check("R5 strobe one cycle", {31'd0, sig_strobe_o}, 32'd0);
    last_sig = exp;
    wcnt     = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni        = 1'b0;
    enable_i      = 1'b1;
    frame_start_i = 1'b0;
    pix_valid_i   = 1'b0;
    pix_data_i    = '0;
    wcnt          = 0;
    lcg           = 32'h1;
    last_sig      = '0;

    repeat (3) @(negedge clk);
    check("R1 reset value", sig_value_o, 32'h0);
    check("R1 reset strobe", {31'd0, sig_strobe_o}, 32'd0);
    rst_ni = 1'b1;

    // R6: words before the first start are ignored; first start reports nothing
    push_word(32'hFFFF_0000);
    push_word(32'h0000_FFFF);
    @(negedge clk);
    frame_start_i = 1'b1;
    pix_valid_i   = 1'b0;
    @(negedge clk);
    frame_start_i = 1'b0;
    check("R6 no report on first start", {31'd0, sig_strobe_o}, 32'd0);
    check("R1 value before first report", sig_value_o, 32'h0);
    wcnt = 0;

    // Table walk: R3/R4 over seeds, lengths and gap patterns
    for (int v = 0; v < NVEC; v++) begin
      lcg = VECS[v].seed;
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        push_word(next_word());
        if (VECS[v].gap != 0 && (i % int'(VECS[v].gap)) == int'(VECS[v].gap) - 1)
          idle_cycle();
      end
      if (VECS[v].len == 8'd16)      close_check("R9 min frame");
      else if (VECS[v].len == 8'd0)  close_check("R2 empty frame");
      else                           close_check("R3 R4 frame");
    end

    // R10: value held across idle cycles
    repeat (5) idle_cycle();
    check("R10 value held", sig_value_o, last_sig);
    check("R10 no strobe", {31'd0, sig_strobe_o}, 32'd0);

    // R7: word coinciding with frame start belongs to the new frame
    lcg = 32'h7777_1111;
    for (int i = 0; i < 3; i++) push_word(next_word());
    begin
      logic [31:0] exp_close;
      logic [31:0] w_ov;
      exp_close = ref_crc(wcnt);
      w_ov      = next_word();
      @(negedge clk);
      frame_start_i = 1'b1;
      pix_valid_i   = 1'b1;
      pix_data_i    = w_ov;
      @(negedge clk);
      frame_start_i = 1'b0;
      pix_valid_i   = 1'b0;
      check("R7 closing strobe", {31'd0, sig_strobe_o}, 32'd1);
      check("R7 closing excludes word", sig_value_o, exp_close);
      wbuf[0] = w_ov;
      wcnt    = 1;
    end
    for (int i = 0; i < 4; i++) push_word(next_word());
    close_check("R7 new frame includes word");

    // R8: disable mid-frame; inputs ignored, frame abandoned
    push_word(32'hA5A5_0F0F);
    push_word(32'h1357_9BDF);
    @(negedge clk);
    enable_i      = 1'b0;
    pix_valid_i   = 1'b0;
    frame_start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      frame_start_i = (i % 2 == 0);
      pix_valid_i   = 1'b1;
      pix_data_i    = 32'h0F0F_0F0F + i;
      check("R8 no strobe while off", {31'd0, sig_strobe_o}, 32'd0);
      check("R8 value held while off", sig_value_o, last_sig);
    end
    @(negedge clk);
    enable_i      = 1'b1;
    frame_start_i = 1'b1;
    pix_valid_i   = 1'b0;
    @(negedge clk);
    frame_start_i = 1'b0;
    check("R8 abandoned frame not reported", {31'd0, sig_strobe_o}, 32'd0);
    check("R8 value after re-enable", sig_value_o, last_sig);
    wcnt = 0;
    lcg  = 32'h2468_ACE0;
    for (int i = 0; i < 5; i++) push_word(next_word());
    close_check("R8 frame after re-enable");

    // R2: back-to-back starts give an empty frame
    close_check("R2 back-to-back empty");
    check("R2 empty value", sig_value_o, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule